// File: doc/BRIEF.md
# Dual-Channel Converter Input Latch

This block is the digital front end of a two-channel 8-bit converter, modelled synchronously. A host writes codes over one shared 8-bit bus using an active-low chip select, an active-low write strobe and a channel-select line. The host pins are asynchronous to the system clock. They pass through a synchronizer, and the block then applies level-transparent latch behaviour at the resolution of the system clock.

While chip select and write are both low, the channel picked by the select line follows the bus on every clock. When either strobe goes high, that channel keeps the last value it followed. While chip select is high, nothing on the bus or the write line has any effect.

Each channel drives its raw code, which is also its unipolar magnitude in 256ths of full scale. Each channel also drives a signed offset-binary view of the code, equal to the code minus 128. A one-cycle update pulse per channel marks the clock in which that channel's held value changes.

Top module: `dual_dac_latch`

## Requirements
- R1: After reset both codes read 0x00, both signed views read -128 and both update pulses are low.
- R2: A change at the host pins reaches the outputs on the third rising clock edge after it was applied. Two edges are spent in the synchronizer and one in the channel register.
- R3: While cs_n=0 and wr_n=0, the selected channel takes the synchronized bus value on every clock, so it follows a changing bus cycle by cycle.
- R4: When wr_n rises while cs_n is low, the selected channel keeps the last value it followed. Later bus changes do not alter it.
- R5: While cs_n=1, both channels hold whatever wr_n, sel_b and bus_in do.
- R6: With both strobes low, sel_b=0 writes channel A only and sel_b=1 writes channel B only. The other channel holds.
- R7: Each signed view equals its code minus 128. 0x80 reads 0, 0xFF reads +127 and 0x00 reads -128.
- R8: upd_a (upd_b) is high for exactly the clock cycles in which code_a (code_b) differs from its value one cycle earlier. Rewriting an unchanged value gives no pulse.
- R9: Toggling sel_b while both strobes stay low moves transparency to the other channel. The channel that is left keeps the last value it followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| sel_b | input | 1 | Channel select: 0 picks channel A, 1 picks channel B |
| bus_in | input | 8 | Shared data bus |
| code_a | output | 8 | Held code of channel A |
| code_b | output | 8 | Held code of channel B |
| bip_a | output | 8 | Signed offset-binary view of channel A |
| bip_b | output | 8 | Signed offset-binary view of channel B |
| upd_a | output | 1 | One-cycle pulse when code_a changes |
| upd_b | output | 1 | One-cycle pulse when code_b changes |

## Verification
A single held write separates the synchronizer latency from the register stage. A bus that changes every clock under steady strobes shows whether transparency is continuous or only edge-captured. Raising the write strobe and then moving the bus, and driving bus and write under a high chip select, separate the hold condition from the transparent one. Switching the select line while the strobes stay low, writing the codes 0x00, 0x80 and 0xFF, and rewriting an unchanged value expose steering faults, offset-mapping faults and spurious update pulses.

// File: rtl/dual_dac_latch.sv
module dual_dac_latch #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 wr_n,
  input  logic                 sel_b,
  input  logic [DW-1:0]        bus_in,
  output logic [DW-1:0]        code_a,
  output logic [DW-1:0]        code_b,
  output logic signed [DW-1:0] bip_a,
  output logic signed [DW-1:0] bip_b,
  output logic                 upd_a,
  output logic                 upd_b
);

  localparam int PW = DW + 3;
  localparam logic [PW-1:0] PIN_IDLE = {1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic [SYNC_STAGES-1:0][PW-1:0] sync_q;
  logic          s_sel, s_wr, s_cs;
  logic [DW-1:0] s_bus;
  logic          wr_go, ld_a, ld_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= PIN_IDLE;
    end else begin
      sync_q[0] <= {sel_b, wr_n, cs_n, bus_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {s_sel, s_wr, s_cs, s_bus} = sync_q[SYNC_STAGES-1];

  assign wr_go = !s_cs && !s_wr;
  assign ld_a  = wr_go && !s_sel;
  assign ld_b  = wr_go && s_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a <= '0;
      code_b <= '0;
      upd_a  <= 1'b0;
      upd_b  <= 1'b0;
    end else begin
      upd_a <= ld_a && (s_bus != code_a);
      upd_b <= ld_b && (s_bus != code_b);
      if (ld_a) code_a <= s_bus;
      if (ld_b) code_b <= s_bus;
    end
  end

  assign bip_a = {~code_a[DW-1], code_a[DW-2:0]};
  assign bip_b = {~code_b[DW-1], code_b[DW-2:0]};

endmodule

// File: rtl/dual_dac_latch_chk.sv
module dual_dac_latch_chk #(
  parameter int DW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_cs,
  input logic                 s_wr,
  input logic                 s_sel,
  input logic [DW-1:0]        s_bus,
  input logic [DW-1:0]        code_a,
  input logic [DW-1:0]        code_b,
  input logic signed [DW-1:0] bip_a,
  input logic                 upd_a,
  input logic                 upd_b
);

  a_r5_cs_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> ($stable(code_a) && $stable(code_b)));

  a_r6_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_a, upd_b}));

  a_r3_follow_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_cs && !s_wr && !s_sel) |=> (code_a == $past(s_bus)));

  a_r8_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    upd_a |-> (code_a != $past(code_a)));

  a_r8_quiet_means_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_b |-> $stable(code_b));

  a_r7_mid_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (code_a == {1'b1, {(DW-1){1'b0}}}) |-> (bip_a == '0));

endmodule

bind dual_dac_latch dual_dac_latch_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .s_cs   (s_cs),
  .s_wr   (s_wr),
  .s_sel  (s_sel),
  .s_bus  (s_bus),
  .code_a (code_a),
  .code_b (code_b),
  .bip_a  (bip_a),
  .upd_a  (upd_a),
  .upd_b  (upd_b)
);

// File: tb/dual_dac_latch_tb_top.sv
module dual_dac_latch_tb_top;
  localparam int DW = 8;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, sel_b = 1'b0;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] code_a, code_b;
  logic signed [DW-1:0] bip_a, bip_b;
  logic upd_a, upd_b;

  always #4 clk = ~clk;

  dual_dac_latch #(.DW(DW), .SYNC_STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .sel_b(sel_b),
    .bus_in(bus_in), .code_a(code_a), .code_b(code_b),
    .bip_a(bip_a), .bip_b(bip_b), .upd_a(upd_a), .upd_b(upd_b));

  int total = 0;
  int bad = 0;
  string tag = "R1";

  logic [DW+2:0] pin_q[$];
  int m_a = 0, m_b = 0;
  bit m_ua = 0, m_ub = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_q.delete();
      m_a = 0; m_b = 0; m_ua = 0; m_ub = 0;
    end else begin
      pin_q.push_back({sel_b, wr_n, cs_n, bus_in});
      m_ua = 0; m_ub = 0;
      if (pin_q.size() > STAGES) begin
        logic [DW+2:0] p;
        p = pin_q.pop_front();
        if (p[DW] == 1'b0 && p[DW+1] == 1'b0) begin
          if (p[DW+2] == 1'b0) begin
            m_ua = (m_a != int'(p[DW-1:0]));
            m_a = int'(p[DW-1:0]);
          end else begin
            m_ub = (m_b != int'(p[DW-1:0]));
            m_b = int'(p[DW-1:0]);
          end
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(tag, "code_a", int'(code_a), m_a);
    chk(tag, "code_b", int'(code_b), m_b);
    chk("R7", "bip_a", int'(bip_a), m_a - 128);
    chk("R7", "bip_b", int'(bip_b), m_b - 128);
    chk("R8", "upd_a", int'(upd_a), int'(m_ua));
    chk("R8", "upd_b", int'(upd_b), int'(m_ub));
  endtask

  task automatic step(logic c, logic w, logic s, logic [DW-1:0] d, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      cs_n = c; wr_n = w; sel_b = s; bus_in = d;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    step(1, 1, 0, 8'h00, 3);
    tag = "R2";
    step(0, 0, 0, 8'h5A, 1);
    step(1, 1, 0, 8'hEE, 4);
    tag = "R3";
    step(0, 0, 0, 8'h11, 1);
    step(0, 0, 0, 8'h22, 1);
    step(0, 0, 0, 8'h80, 1);
    step(0, 0, 0, 8'hFF, 1);
    step(0, 0, 0, 8'h00, 1);
    step(0, 0, 0, 8'h80, 4);
    tag = "R4";
    step(0, 0, 0, 8'h3C, 2);
    step(0, 1, 0, 8'hC3, 1);
    step(0, 1, 0, 8'h99, 5);
    tag = "R5";
    step(1, 0, 0, 8'h44, 2);
    step(1, 0, 1, 8'h55, 2);
    step(1, 1, 1, 8'h66, 5);
    tag = "R6";
    step(0, 0, 1, 8'hFF, 2);
    step(0, 0, 1, 8'h80, 2);
    step(0, 1, 1, 8'h80, 4);
    step(0, 0, 0, 8'h01, 2);
    step(1, 1, 0, 8'h01, 4);
    tag = "R9";
    step(0, 0, 0, 8'h77, 2);
    step(0, 0, 1, 8'h99, 2);
    step(0, 0, 0, 8'h12, 2);
    step(1, 1, 0, 8'h12, 5);
    tag = "R8";
    step(0, 0, 0, 8'h12, 3);
    step(0, 0, 1, 8'h99, 3);
    step(0, 0, 1, 8'h9A, 1);
    step(1, 1, 1, 8'h00, 5);
    tag = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 1, 0, 8'h00, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule